// File: doc/BRIEF.md
# Dual-Granularity Memory Port Unit

This block places two processor-side access paths in front of a single byte-organised storage array that it holds internally. The data path counts in 32-bit words. The caller presents a word address together with read or write strobes, and a 32-bit data register receives the read results. The instruction path counts in bytes and can only read. It takes a byte address and a fetch strobe, and returns one byte in the low eight bits of a 32-bit fetch buffer.

Both paths share the same storage. The word address is turned into a physical byte address by moving every bit up by two positions. The two most significant bits of the word address are dropped, and the two lowest physical address lines are held at zero. The resulting physical address is also visible on an output. Bytes sit big-endian inside a word. Both paths may operate in the same clock cycle, and each returns its read result one clock after its strobe.

Top module: `dual_gran_mem_port`

## Requirements
- R1: `phys_addr` equals `{wa_addr[29:0], 2'b00}`: word address bit k drives physical line k+2, lines 1:0 are zero, and word address bits 31:30 have no effect.
- R2: When `wa_rd` is sampled high with `wa_wr` low, `wa_rdata` holds the word at physical bytes P..P+3 (P = `phys_addr`) from the next clock on. The byte at P lands in bits 31:24 and the byte at P+3 lands in bits 7:0.
- R3: A write (`wa_wr` high) commits `wa_wdata` at the sampling clock edge, big-endian: bits 31:24 go to byte P and bits 7:0 go to byte P+3.
- R4: When `fp_rd` is sampled high, `fp_data` holds the byte at byte address `fp_addr` in bits 7:0, with bits 31:8 zero, from the next clock on.
- R5: When `wa_rd` and `wa_wr` are both high, the write is carried out and the read is dropped, so `wa_rdata` keeps its previous value.
- R6: When a word write and a fetch address the same word in one cycle, the fetch returns the byte as it was before the write, and the write still lands.
- R7: Without a strobe, `wa_rdata` and `fp_data` keep their values.
- R8: A synchronous active-high `rst` clears `wa_rdata`, `fp_data` and every stored byte to zero.
- R9: Addresses beyond the storage size wrap modulo `MEM_BYTES` on both ports, using the low address bits of the physical byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_addr | input | 32 | Word address register value |
| wa_wdata | input | 32 | Word data to be written |
| wa_rd | input | 1 | Word read strobe |
| wa_wr | input | 1 | Word write strobe |
| wa_rdata | output | 32 | Word data register (read result) |
| phys_addr | output | 32 | Physical byte address derived from `wa_addr` |
| fp_addr | input | 32 | Fetch byte address |
| fp_rd | input | 1 | Fetch strobe |
| fp_data | output | 32 | Fetch buffer: byte in bits 7:0, zeros above |

## Verification
The bench builds the unit with `MEM_BYTES = 64`, which gives sixteen words of storage. At that size the word address 17 and the byte address 68 fold back onto word 1 and byte 4, so a few vectors are enough to exercise the wrap on both ports. The small array also keeps the reset-clear check cheap. Word addresses with bits 31:30 set are used to show on `phys_addr` that those bits are dropped, and to show that the same storage is read through them.

// File: rtl/dgm_pkg.sv
package dgm_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Request on the word-granular port
    typedef struct packed {
        logic  wr;
        logic  rd;
        word_t addr;
        word_t data;
    } wreq_t;

    // Request on the byte-granular fetch port
    typedef struct packed {
        logic  rd;
        word_t addr;
    } freq_t;

    // Big-endian lane extraction: lane 0 is the most significant byte
    function automatic byte_t be_lane(input word_t w, input logic [1:0] lane);
        return w[WORD_W-1 - BYTE_W*lane -: BYTE_W];
    endfunction

    // Word count to byte count: shift up two, drop the top two bits
    function automatic word_t word_to_byte(input word_t wa);
        return {wa[WORD_W-3:0], 2'b00};
    endfunction

    // Zero-extend a fetched byte into the fetch buffer
    function automatic word_t byte_to_buf(input byte_t b);
        return {{(WORD_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/dgm_addr_map.sv
module dgm_addr_map
    import dgm_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  word_t              word_addr,
    input  word_t              byte_addr,
    output word_t              phys_addr,
    output logic [IDX_W-3:0]   word_idx,
    output logic [IDX_W-1:0]   fetch_idx
);

    word_t phys;

    always_comb begin
        phys      = word_to_byte(word_addr);
        phys_addr = phys;
        word_idx  = phys[IDX_W-1:2];
        fetch_idx = byte_addr[IDX_W-1:0];
    end

endmodule

// File: rtl/dgm_byte_mem.sv
module dgm_byte_mem
    import dgm_pkg::*;
#(
    parameter int MEM_BYTES = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [$clog2(MEM_BYTES)-3:0]  widx,
    input  word_t                         wdata,
    output word_t                         rdata,
    input  logic                          f_en,
    input  logic [$clog2(MEM_BYTES)-1:0]  f_idx,
    output word_t                         f_data
);

    localparam int IDX_W = $clog2(MEM_BYTES);

    byte_t mem [MEM_BYTES];
    byte_t lane_rd [LANES];

    // Combinational view of the addressed word, lane by lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb lane_rd[g] = mem[{widx, 2'(g)}];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++)
                mem[{widx, 2'(b)}] <= be_lane(wdata, 2'(b));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= {lane_rd[0], lane_rd[1], lane_rd[2], lane_rd[3]};
    end

    // Fetch samples the array before this edge's write: old contents win
    always_ff @(posedge clk) begin
        if (rst)       f_data <= '0;
        else if (f_en) f_data <= byte_to_buf(mem[f_idx]);
    end

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rdata));

    p_f_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(f_en)) |-> $stable(f_data));

    initial begin
        a_size_r9: assert (MEM_BYTES >= 8 && (1 << IDX_W) == MEM_BYTES);
    end

endmodule

// File: rtl/dual_gran_mem_port.sv
module dual_gran_mem_port
    import dgm_pkg::*;
#(
    parameter int MEM_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] wa_addr,
    input  logic [31:0] wa_wdata,
    input  logic        wa_rd,
    input  logic        wa_wr,
    output logic [31:0] wa_rdata,
    output logic [31:0] phys_addr,
    input  logic [31:0] fp_addr,
    input  logic        fp_rd,
    output logic [31:0] fp_data
);

    localparam int IDX_W = $clog2(MEM_BYTES);

    wreq_t            wq;
    freq_t            fq;
    logic [IDX_W-3:0] widx;
    logic [IDX_W-1:0] fidx;
    logic             rd_go;

    always_comb begin
        wq    = '{wr: wa_wr, rd: wa_rd, addr: wa_addr, data: wa_wdata};
        fq    = '{rd: fp_rd, addr: fp_addr};
        rd_go = wq.rd && !wq.wr;   // write wins over a simultaneous read
    end

    dgm_addr_map #(.IDX_W(IDX_W)) u_map (
        .word_addr (wq.addr),
        .byte_addr (fq.addr),
        .phys_addr (phys_addr),
        .word_idx  (widx),
        .fetch_idx (fidx)
    );

    dgm_byte_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wq.wr),
        .rd_en  (rd_go),
        .widx   (widx),
        .wdata  (wq.data),
        .rdata  (wa_rdata),
        .f_en   (fq.rd),
        .f_idx  (fidx),
        .f_data (fp_data)
    );

    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> (wa_rdata == '0 && fp_data == '0));

    p_both_strobes_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wa_wr) && $past(wa_rd)) |-> $stable(wa_rdata));

    p_wr_then_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(wa_wr, 2) && $past(wa_rd)
         && !$past(wa_wr)
         && $past(phys_addr[IDX_W-1:2]) == $past(phys_addr[IDX_W-1:2], 2))
        |-> wa_rdata == $past(wa_wdata, 2));

    p_wr_then_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(wa_wr, 2) && $past(fp_rd)
         && !$past(wa_wr)
         && $past(fp_addr[IDX_W-1:2]) == $past(phys_addr[IDX_W-1:2], 2))
        |-> fp_data == byte_to_buf(be_lane($past(wa_wdata, 2), $past(fp_addr[1:0]))));

endmodule

// File: tb/dual_gran_mem_port_tb.sv
module dual_gran_mem_port_tb;

    localparam int MEMB = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] wa_addr, wa_wdata, wa_rdata, phys_addr, fp_addr, fp_data;
    logic        wa_rd, wa_wr, fp_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_gran_mem_port #(.MEM_BYTES(MEMB)) u_dut (
        .clk(clk), .rst(rst),
        .wa_addr(wa_addr), .wa_wdata(wa_wdata), .wa_rd(wa_rd), .wa_wr(wa_wr),
        .wa_rdata(wa_rdata), .phys_addr(phys_addr),
        .fp_addr(fp_addr), .fp_rd(fp_rd), .fp_data(fp_data)
    );

    // op: 0 word write, 1 word read (check wa_rdata), 2 fetch (check fp_data)
    localparam int NV = 13;
    localparam logic [97:0] VEC [NV] = '{
        {2'd0, 32'h0000_0002, 32'h1122_3344, 32'h0},           // R3
        {2'd1, 32'h0000_0002, 32'h0,         32'h1122_3344},   // R2
        {2'd2, 32'h0000_0008, 32'h0,         32'h0000_0011},   // R4
        {2'd2, 32'h0000_000B, 32'h0,         32'h0000_0044},   // R4
        {2'd2, 32'h0000_000A, 32'h0,         32'h0000_0033},   // R4
        {2'd0, 32'h0000_0000, 32'hA0B1_C2D3, 32'h0},           // R3
        {2'd2, 32'h0000_0002, 32'h0,         32'h0000_00C2},   // R4
        {2'd1, 32'h0000_0000, 32'h0,         32'hA0B1_C2D3},   // R2
        {2'd0, 32'h0000_0011, 32'hDEAD_BEEF, 32'h0},           // R9
        {2'd1, 32'h0000_0001, 32'h0,         32'hDEAD_BEEF},   // R9
        {2'd2, 32'h0000_0044, 32'h0,         32'h0000_00DE},   // R9
        {2'd1, 32'h8000_0002, 32'h0,         32'h1122_3344},   // R1
        {2'd2, 32'h0000_0007, 32'h0,         32'h0000_00EF}    // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wa_rd = 0; wa_wr = 0; fp_rd = 0;
    endtask

    // Drive after a falling edge; the rising edge samples; look at next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] prev;
        rst = 1; idle();
        wa_addr = 0; wa_wdata = 0; fp_addr = 0;
        @(negedge clk); step(); step();
        rst = 0;
        // R8: register outputs cleared
        check("R8 rdata", wa_rdata, 32'h0);
        check("R8 fdata", fp_data, 32'h0);
        wa_addr = 32'd5; wa_rd = 1; fp_addr = 32'd21; fp_rd = 1;
        step(); idle();
        check("R8 mem word", wa_rdata, 32'h0);
        check("R8 mem byte", fp_data, 32'h0);

        // R1: mapping visible on phys_addr
        wa_addr = 32'h0000_0001; #1 check("R1 addr1", phys_addr, 32'h0000_0004);
        wa_addr = 32'h0000_0002; #1 check("R1 addr2", phys_addr, 32'h0000_0008);
        wa_addr = 32'hC000_0003; #1 check("R1 top bits", phys_addr, 32'h0000_000C);
        wa_addr = 32'h3FFF_FFFF; #1 check("R1 max", phys_addr, 32'hFFFF_FFFC);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [31:0] a, d, e;
            {op, a, d, e} = VEC[i];
            idle();
            case (op)
                2'd0: begin wa_addr = a; wa_wdata = d; wa_wr = 1; end
                2'd1: begin wa_addr = a; wa_rd = 1; end
                default: begin fp_addr = a; fp_rd = 1; end
            endcase
            step(); idle();
            if (op == 2'd1) check("R2 vector read", wa_rdata, e);
            if (op == 2'd2) check("R4 vector fetch", fp_data, e);
        end

        // R7: no strobes, outputs hold
        prev = wa_rdata;
        wa_addr = 32'd0; fp_addr = 32'd0;
        step(); step();
        check("R7 rdata hold", wa_rdata, prev);
        check("R7 fdata hold", fp_data, 32'h0000_00EF);

        // R5: read and write together, write wins, read dropped
        wa_addr = 32'd3; wa_wdata = 32'h5566_7788; wa_wr = 1; wa_rd = 1;
        step(); idle();
        check("R5 rdata kept", wa_rdata, prev);
        wa_rd = 1; step(); idle();
        check("R5 write landed", wa_rdata, 32'h5566_7788);

        // R6: write and fetch on the same word in one cycle
        wa_addr = 32'd2; wa_wdata = 32'hCAFE_F00D; wa_wr = 1;
        fp_addr = 32'd9; fp_rd = 1;
        step(); idle();
        check("R6 old byte", fp_data, 32'h0000_0022);
        fp_rd = 1; step(); idle();
        check("R6 new byte", fp_data, 32'h0000_00FE);
        wa_rd = 1; step(); idle();
        check("R6 write landed", wa_rdata, 32'hCAFE_F00D);

        // R3: little end of word lands at highest byte
        fp_addr = 32'd11; fp_rd = 1; step(); idle();
        check("R3 low lane", fp_data, 32'h0000_000D);

        // R8: reset clears storage again
        rst = 1; step(); rst = 0;
        wa_addr = 32'd2; wa_rd = 1; step(); idle();
        check("R8 cleared", wa_rdata, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule